// File: doc/BRIEF.md
# Single-Round DES Step Unit

This block carries out one round of the Data Encryption Standard each time it is started. It keeps no state between steps of its own. The caller holds the 64-bit data word and the 64-bit key word, for example in a register file. On each step the caller presents both words together with a round number and a direction bit. The block returns the updated data and key words one cycle later. A full block cipher operation is sixteen steps, with round numbers 0 through 15 issued in increasing order. Each step feeds the previous step's outputs back in.

Round 0 applies the initial permutation before its Feistel round. Round 15 undoes the final half swap and applies the final permutation, so after that step the data output is the finished ciphertext or plaintext. The key word is kept in its ordinary 64-bit form with its parity bits untouched.

In encryption the key halves are rotated left before they are used. In decryption they are used first and then rotated right. Either way the sixteen rotations add up to a full turn of each 28-bit half, so the key output after round 15 equals the key that was supplied to round 0.

Top module: `des_step`

## Requirements
- R1: `done` is high for exactly the one cycle that follows a cycle with `start` high, and it is low after any cycle with `start` low; `data_out` and `key_out` are valid while `done` is high.
- R2: While `start` is low, `data_out` and `key_out` keep their values and `done` stays low.
- R3: A step with round number 0 applies the initial permutation to `data_in` before the round. For key 133457799BBCDFF1 and data 0123456789ABCDEF in encryption (`dir` = 0), the data output is F0AAF0AAEF4A6544: the left half is the permuted right half and the right half is the new Feistel result.
- R4: Sixteen encryption steps (`dir` = 0), rounds 0 to 15 in order with each output fed back, produce the standard ciphertext. Key 133457799BBCDFF1 with data 0123456789ABCDEF gives 85E813540F0AB405. Key 0E329232EA6D0D73 with data 8787878787878787 gives 0000000000000000.
- R5: Sixteen decryption steps (`dir` = 1) with the same key invert R4, so decrypting the ciphertext of any block with the same key returns the original block.
- R6: After the step with round number 15, in either direction, `key_out` equals the key given to the round-0 step, parity bits included.
- R7: The subkey rotation per round is 1 bit for round positions 0, 1, 8 and 15 of the encryption schedule and 2 bits for the others. In encryption it is applied to the left before the subkey is taken. In decryption it is applied to the right after the subkey is taken, in reverse schedule order.
- R8: A synchronous active-high `rst` clears `data_out`, `key_out` and `done` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Execute one round this cycle |
| round_num | input | 4 | Round to execute, 0 to 15 |
| dir | input | 1 | 0 encrypts, 1 decrypts |
| data_in | input | 64 | Data word from the caller's storage |
| key_in | input | 64 | Key word from the caller's storage |
| data_out | output | 64 | Updated data word |
| key_out | output | 64 | Updated key word |
| done | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
The assertions assume that `start` is a synchronous level with no meaning outside the cycle it is sampled. They also assume that round number, direction and words only matter in a cycle with `start` high, so they check pulse timing and output holding alone. Whether the cipher result is correct depends on the caller issuing rounds 0 to 15 in order and feeding each output back. The stimulus does exactly that for every full operation. The one isolated round-0 step is checked only against its own known output. Idle cycles between operations exercise the hold behaviour.

// File: rtl/des_step_pkg.sv
package des_step_pkg;

    localparam int BLK_W   = 64;
    localparam int HALF_W  = BLK_W / 2;
    localparam int SUB_W   = 48;
    localparam int CD_W    = 56;
    localparam int HCD_W   = CD_W / 2;
    localparam int ROUND_W = 4;
    localparam int NUM_BOX = 8;
    localparam int BOX_IN  = SUB_W / NUM_BOX;
    localparam int BOX_OUT = HALF_W / NUM_BOX;
    localparam int LAST_ROUND = (1 << ROUND_W) - 1;

    typedef logic [BLK_W-1:0]   blk_t;
    typedef logic [HALF_W-1:0]  half_t;
    typedef logic [SUB_W-1:0]   sub_t;
    typedef logic [HCD_W-1:0]   hcd_t;
    typedef logic [ROUND_W-1:0] round_t;

    typedef struct packed {
        half_t lft;
        half_t rgt;
    } halves_t;

    typedef struct packed {
        hcd_t c;
        hcd_t d;
    } cd_t;

    typedef enum logic { DIR_ENC = 1'b0, DIR_DEC = 1'b1 } dir_e;

    // Substitution boxes: rows of 16 nibbles, row 0 in the top bits.
    localparam logic [255:0] SBOX [NUM_BOX] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    // Straight permutation after the boxes (1-based source bit, MSB first).
    localparam logic [7:0] P_TBL [HALF_W] = '{
        8'd16, 8'd7,  8'd20, 8'd21, 8'd29, 8'd12, 8'd28, 8'd17,
        8'd1,  8'd15, 8'd23, 8'd26, 8'd5,  8'd18, 8'd31, 8'd10,
        8'd2,  8'd8,  8'd24, 8'd14, 8'd32, 8'd27, 8'd3,  8'd9,
        8'd19, 8'd13, 8'd30, 8'd6,  8'd22, 8'd11, 8'd4,  8'd25
    };

    // Key selection from the 64-bit key word into the two 28-bit halves.
    localparam logic [7:0] PC1_TBL [CD_W] = '{
        8'd57, 8'd49, 8'd41, 8'd33, 8'd25, 8'd17, 8'd9,
        8'd1,  8'd58, 8'd50, 8'd42, 8'd34, 8'd26, 8'd18,
        8'd10, 8'd2,  8'd59, 8'd51, 8'd43, 8'd35, 8'd27,
        8'd19, 8'd11, 8'd3,  8'd60, 8'd52, 8'd44, 8'd36,
        8'd63, 8'd55, 8'd47, 8'd39, 8'd31, 8'd23, 8'd15,
        8'd7,  8'd62, 8'd54, 8'd46, 8'd38, 8'd30, 8'd22,
        8'd14, 8'd6,  8'd61, 8'd53, 8'd45, 8'd37, 8'd29,
        8'd21, 8'd13, 8'd5,  8'd28, 8'd20, 8'd12, 8'd4
    };

    // Subkey selection from the rotated halves.
    localparam logic [7:0] PC2_TBL [SUB_W] = '{
        8'd14, 8'd17, 8'd11, 8'd24, 8'd1,  8'd5,  8'd3,  8'd28,
        8'd15, 8'd6,  8'd21, 8'd10, 8'd23, 8'd19, 8'd12, 8'd4,
        8'd26, 8'd8,  8'd16, 8'd7,  8'd27, 8'd20, 8'd13, 8'd2,
        8'd41, 8'd52, 8'd31, 8'd37, 8'd47, 8'd55, 8'd30, 8'd40,
        8'd51, 8'd45, 8'd33, 8'd48, 8'd44, 8'd49, 8'd39, 8'd56,
        8'd34, 8'd53, 8'd46, 8'd42, 8'd50, 8'd36, 8'd29, 8'd32
    };

    // Source bit (1-based) of output position i of the initial permutation.
    function automatic int ip_src(input int i);
        int row;
        int col;
        int base;
        row  = i / 8;
        col  = i % 8;
        base = (row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4));
        return base - 8 * col;
    endfunction

    function automatic blk_t apply_ip(input blk_t x);
        blk_t y;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-ip_src(i)];
        return y;
    endfunction

    function automatic blk_t apply_fp(input blk_t x);
        blk_t y;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-ip_src(i)] = x[BLK_W-1-i];
        return y;
    endfunction

    function automatic sub_t expand(input half_t r);
        sub_t y;
        int   src;
        for (int j = 0; j < SUB_W; j++) begin
            src = (BOX_OUT * (j / BOX_IN) + (j % BOX_IN) - 1 + HALF_W) % HALF_W;
            y[SUB_W-1-j] = r[HALF_W-1-src];
        end
        return y;
    endfunction

    function automatic logic [BOX_OUT-1:0] sbox_get(input int box, input logic [BOX_IN-1:0] b);
        int n;
        n = 16 * int'({b[5], b[0]}) + int'(b[4:1]);
        return SBOX[box][255-4*n -: 4];
    endfunction

    function automatic half_t p_perm(input half_t x);
        half_t y;
        for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-int'(P_TBL[i])];
        return y;
    endfunction

    function automatic cd_t pc1(input blk_t k);
        cd_t y;
        for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[BLK_W-int'(PC1_TBL[i])];
        return y;
    endfunction

    // Put the halves back into key-word form; parity bits come from orig.
    function automatic blk_t pc1_inv(input cd_t cd, input blk_t orig);
        blk_t y;
        y = orig;
        for (int i = 0; i < CD_W; i++) y[BLK_W-int'(PC1_TBL[i])] = cd[CD_W-1-i];
        return y;
    endfunction

    function automatic sub_t pc2(input cd_t cd);
        sub_t y;
        for (int i = 0; i < SUB_W; i++) y[SUB_W-1-i] = cd[CD_W-int'(PC2_TBL[i])];
        return y;
    endfunction

    function automatic logic one_bit_shift(input round_t r);
        return (r == round_t'(0)) || (r == round_t'(1)) ||
               (r == round_t'(8)) || (r == round_t'(LAST_ROUND));
    endfunction

    function automatic hcd_t rot_left(input hcd_t x, input logic one);
        return one ? {x[HCD_W-2:0], x[HCD_W-1]} : {x[HCD_W-3:0], x[HCD_W-1:HCD_W-2]};
    endfunction

    function automatic hcd_t rot_right(input hcd_t x, input logic one);
        return one ? {x[0], x[HCD_W-1:1]} : {x[1:0], x[HCD_W-1:2]};
    endfunction

endpackage

// File: rtl/des_perm_stage.sv
module des_perm_stage
    import des_step_pkg::*;
#(
    parameter bit FINAL = 1'b0
) (
    input  blk_t din,
    output blk_t dout
);
    generate
        if (FINAL) begin : g_final
            assign dout = apply_fp(din);
        end else begin : g_initial
            assign dout = apply_ip(din);
        end
    endgenerate
endmodule

// File: rtl/des_key_step.sv
module des_key_step
    import des_step_pkg::*;
(
    input  blk_t   key_in,
    input  round_t round_num,
    input  dir_e   dir,
    output sub_t   subkey,
    output blk_t   key_next
);
    cd_t    cd_cur;
    cd_t    cd_enc;
    cd_t    cd_dec;
    logic   one_enc;
    logic   one_dec;
    round_t mirror;

    assign cd_cur  = pc1(key_in);
    assign mirror  = round_t'(LAST_ROUND) - round_num;
    assign one_enc = one_bit_shift(round_num);
    assign one_dec = one_bit_shift(mirror);

    // Encryption: rotate left first, then select the subkey.
    assign cd_enc.c = rot_left(cd_cur.c, one_enc);
    assign cd_enc.d = rot_left(cd_cur.d, one_enc);
    // Decryption: select from the current halves, then rotate right.
    assign cd_dec.c = rot_right(cd_cur.c, one_dec);
    assign cd_dec.d = rot_right(cd_cur.d, one_dec);

    always_comb begin
        if (dir == DIR_DEC) begin
            subkey   = pc2(cd_cur);
            key_next = pc1_inv(cd_dec, key_in);
        end else begin
            subkey   = pc2(cd_enc);
            key_next = pc1_inv(cd_enc, key_in);
        end
    end
endmodule

// File: rtl/des_feistel.sv
module des_feistel
    import des_step_pkg::*;
(
    input  half_t rgt,
    input  sub_t  subkey,
    output half_t f_out
);
    sub_t  mixed;
    half_t boxed;

    assign mixed = expand(rgt) ^ subkey;

    genvar g;
    generate
        for (g = 0; g < NUM_BOX; g++) begin : g_box
            assign boxed[HALF_W-1-BOX_OUT*g -: BOX_OUT] =
                sbox_get(g, mixed[SUB_W-1-BOX_IN*g -: BOX_IN]);
        end
    endgenerate

    assign f_out = p_perm(boxed);
endmodule

// File: rtl/des_step.sv
module des_step
    import des_step_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  round_num,
    input  logic        dir,
    input  logic [63:0] data_in,
    input  logic [63:0] key_in,
    output logic [63:0] data_out,
    output logic [63:0] key_out,
    output logic        done
);
    blk_t    ip_out;
    halves_t pre;
    halves_t post;
    halves_t unswapped;
    blk_t    fp_out;
    blk_t    data_next;
    blk_t    key_next;
    sub_t    subkey;
    half_t   f_val;
    dir_e    dir_sel;

    assign dir_sel = dir_e'(dir);

    des_perm_stage #(.FINAL(1'b0)) u_ip (
        .din  (data_in),
        .dout (ip_out)
    );

    assign pre = (round_num == round_t'(0)) ? ip_out : data_in;

    des_key_step u_key (
        .key_in    (key_in),
        .round_num (round_num),
        .dir       (dir_sel),
        .subkey    (subkey),
        .key_next  (key_next)
    );

    des_feistel u_f (
        .rgt    (pre.rgt),
        .subkey (subkey),
        .f_out  (f_val)
    );

    assign post.lft      = pre.rgt;
    assign post.rgt      = pre.lft ^ f_val;
    assign unswapped.lft = post.rgt;
    assign unswapped.rgt = post.lft;

    des_perm_stage #(.FINAL(1'b1)) u_fp (
        .din  (unswapped),
        .dout (fp_out)
    );

    assign data_next = (round_num == round_t'(LAST_ROUND)) ? fp_out : blk_t'(post);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            key_out  <= '0;
            done     <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                data_out <= data_next;
                key_out  <= key_next;
            end
        end
    end
endmodule

// File: rtl/des_step_chk.sv
module des_step_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [63:0] data_out,
    input logic [63:0] key_out,
    input logic        done
);
    // R1: a started step reports completion in the next cycle
    p_done_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R1, R2: no completion pulse without a start
    p_no_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R2: data word holds while idle
    p_hold_data_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(data_out));

    // R2: key word holds while idle
    p_hold_key_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(key_out));

    // R8: reset clears the pulse
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> !done);
endmodule

bind des_step des_step_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .data_out (data_out),
    .key_out  (key_out),
    .done     (done)
);

// File: tb/des_step_bench.sv
`timescale 1ns/1ps
module des_step_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  round_num = '0;
    logic        dir = 1'b0;
    logic [63:0] data_in = '0;
    logic [63:0] key_in = '0;
    logic [63:0] data_out;
    logic [63:0] key_out;
    logic        done;

    always #2.5 clk = ~clk;

    des_step u_des_step (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .round_num (round_num),
        .dir       (dir),
        .data_in   (data_in),
        .key_in    (key_in),
        .data_out  (data_out),
        .key_out   (key_out),
        .done      (done)
    );

    typedef struct {
        bit          chk_d;
        bit          chk_k;
        logic [63:0] exp_d;
        logic [63:0] exp_k;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 0;

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Monitor: every done pulse consumes one scoreboard entry (R1).
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R1 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.chk_d) check64({e.tag, " data"}, data_out, e.exp_d);
                if (e.chk_k) check64({e.tag, " key"}, key_out, e.exp_k);
            end
        end
    end

    task automatic step(input logic [3:0] rn, input logic dr,
                        input logic [63:0] d, input logic [63:0] k,
                        input exp_t e,
                        output logic [63:0] dq, output logic [63:0] kq);
        sb_q.push_back(e);
        @(negedge clk);
        start = 1'b1; round_num = rn; dir = dr; data_in = d; key_in = k;
        @(negedge clk);
        start = 1'b0;
        dq = data_out;
        kq = key_out;
    endtask

    // Full sixteen-round operation with feedback (R4, R5, R6, R7).
    task automatic run16(input logic dr, input logic [63:0] d, input logic [63:0] k,
                         input bit chk_final, input logic [63:0] exp_final,
                         input string tag, output logic [63:0] res);
        logic [63:0] cur_d;
        logic [63:0] cur_k;
        exp_t e;
        cur_d = d;
        cur_k = k;
        for (int r = 0; r < 16; r++) begin
            e.chk_d = (r == 15) && chk_final;
            e.chk_k = (r == 15);
            e.exp_d = exp_final;
            e.exp_k = k;
            e.tag   = tag;
            step(4'(r), dr, cur_d, cur_k, e, cur_d, cur_k);
        end
        res = cur_d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [63:0] res;
        logic [63:0] held_d;
        logic [63:0] held_k;
        logic [63:0] dq;
        logic [63:0] kq;
        exp_t e;

        repeat (3) @(negedge clk);
        // R8: reset state
        check64("R8 data_out after reset", data_out, 64'h0);
        check64("R8 key_out after reset", key_out, 64'h0);
        check64("R8 done after reset", {63'h0, done}, 64'h0);
        rst = 1'b0;
        @(negedge clk);

        // R3: isolated round-0 encryption step
        e.chk_d = 1; e.chk_k = 0; e.exp_d = 64'hF0AAF0AA_EF4A6544; e.exp_k = '0;
        e.tag = "R3 round0 IP";
        step(4'd0, 1'b0, 64'h0123456789ABCDEF, 64'h133457799BBCDFF1, e, dq, kq);
        // R1: pulse ends after one cycle
        @(negedge clk);
        check64("R1 done single cycle", {63'h0, done}, 64'h0);

        // R4, R6, R7: known encryption vectors
        run16(1'b0, 64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 1, 64'h85E813540F0AB405,
              "R4 enc vec1 / R6 key", res);

        // R2: hold while idle
        held_d = data_out;
        held_k = key_out;
        repeat (3) @(negedge clk);
        check64("R2 data held", data_out, held_d);
        check64("R2 key held", key_out, held_k);
        check64("R2 done low idle", {63'h0, done}, 64'h0);

        run16(1'b0, 64'h8787878787878787, 64'h0E329232EA6D0D73, 1, 64'h0,
              "R4 enc vec2 / R6 key", res);

        // R5, R6, R7: decryption of known vectors
        run16(1'b1, 64'h85E813540F0AB405, 64'h133457799BBCDFF1, 1, 64'h0123456789ABCDEF,
              "R5 dec vec1 / R6 key", res);
        run16(1'b1, 64'h0, 64'h0E329232EA6D0D73, 1, 64'h8787878787878787,
              "R5 dec vec2 / R6 key", res);

        // R5: round trip with arbitrary blocks and keys
        run16(1'b0, 64'hA5A55A5A_0F1E2D3C, 64'hFEDCBA9876543210, 0, 64'h0,
              "R5 trip1 enc / R6 key", res);
        run16(1'b1, res, 64'hFEDCBA9876543210, 1, 64'hA5A55A5A_0F1E2D3C,
              "R5 trip1 dec / R6 key", res);
        run16(1'b0, 64'hFFFFFFFF_00000000, 64'h0123456789ABCDEF, 0, 64'h0,
              "R5 trip2 enc / R6 key", res);
        run16(1'b1, res, 64'h0123456789ABCDEF, 1, 64'hFFFFFFFF_00000000,
              "R5 trip2 dec / R6 key", res);

        repeat (3) @(negedge clk);
        // R1: every step produced exactly one pulse
        check64("R1 scoreboard drained", 64'(sb_q.size()), 64'h0);

        // R8: reset after activity
        rst = 1'b1;
        @(negedge clk);
        check64("R8 data_out cleared", data_out, 64'h0);
        check64("R8 key_out cleared", key_out, 64'h0);
        summary();
    end

endmodule